// File: doc/BRIEF.md
# Asynchronous Byte Deframer with Strobe Host Interface

This block receives an already-demodulated asynchronous serial stream running at 1200 baud. Each frame holds a low start bit, eight data bits sent least-significant first, and a high stop bit. The block presents every byte to a host over three wires: a data line, a data clock and an active-low data-ready line. Timing comes from a system clock and a single-cycle enable, `os_tick`, which pulses sixteen times per bit period. The receiver waits for a low level, confirms it at the middle of the start bit, and then samples each later bit at its mid-point.

The `mode` input chooses between two host interfaces. In stream mode (`mode` = 0) the serial input is passed straight to the data line. The block generates exactly eight data-clock pulses per frame, one centred on each data bit, and pulses data-ready low from the start of the stop bit to its middle. In buffer mode (`mode` = 1) the eight data bits and the stop bit are captured into a nine-bit register. Data-ready goes low when that register is loaded. The host then reads the register bit by bit, one `host_shift` strobe per bit, from the data line. A frame whose stop bit samples low raises a one-cycle framing-error pulse in either mode.

Top module: `fsk_deframer`

## Requirements
- R1: While `rst` is held and in the first cycle after it is released, `dclk_out` is 0, `dr_n` is 1 and `frame_err` is 0 in both modes. In buffer mode `data_out` is 1, because the register resets to all ones.
- R2: In stream mode `data_out` equals `serial_in` in the same cycle.
- R3: Tick t0 is the first tick that sees the line low. For every accepted frame, `dclk_out` rises exactly 8 times. Rise i (i = 0..7) appears one clock after tick t(24+16i), and the matching fall appears one clock after tick t(32+16i), so each pulse is high for half a bit.
- R4: `dclk_out` stays low during the start bit and the stop bit. In buffer mode it is always low.
- R5: In stream mode `dr_n` goes low one clock after tick t144, which is the first tick of the stop bit. It returns high one clock after tick t152, the middle of the stop bit, so it is low for 8 ticks.
- R6: If the line is high at the start-bit sample (tick t8), the block returns to waiting for a start bit. It then produces no data-clock pulse, no data-ready pulse and no framing error, and it receives the next frame normally.
- R7: A byte assembled from `data_out` at each rising edge of `dclk_out`, with the first bit placed in bit 0, equals the byte that was sent.
- R8: At tick t152 the nine-bit register is loaded with the stop bit in bit 8 and data bit k in bit k. In buffer mode `data_out` shows register bit 0. Each `host_shift` cycle moves the register down one place and fills the top with 1, so the host reads d0..d7, then the stop bit, then 1.
- R9: In buffer mode `dr_n` goes low in the cycle after the register is loaded. It goes high in the cycle after the first `host_shift`.
- R10: When the stop bit samples 0, `frame_err` is high for exactly one cycle, one clock after tick t152. It stays low for a frame with a good stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable, 16 per bit period |
| serial_in | input | 1 | Demodulated serial bit stream, idle high |
| mode | input | 1 | 0 = stream mode, 1 = buffer mode |
| host_shift | input | 1 | Buffer mode: advance the read register by one bit |
| data_out | output | 1 | Stream mode: `serial_in`; buffer mode: register bit 0 |
| dclk_out | output | 1 | Data clock, high for the second half of each data bit |
| dr_n | output | 1 | Active-low data ready |
| frame_err | output | 1 | One-cycle pulse when the stop bit samples low |

## Verification
Some behaviours are checked by assertions on every cycle:
- the data clock is high only inside data bits, and it shows eight rising edges before each stop sample;
- each data-clock pulse and the stop-bit data-ready pulse last exactly half a bit;
- a rejected start bit sends the receiver back to waiting;
- the buffer-mode ready flag responds to loads and reads;
- the framing-error pulse lasts a single cycle.

Other behaviours can only be shown by the bench's scenarios:
- the exact cycle of every edge relative to the start of the frame;
- the recovered byte value and its bit order;
- the bit order the host reads back in buffer mode;
- behaviour across random bytes, random idle gaps and injected stop-bit errors.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    // One-cycle receive events produced by the timing engine
    typedef struct packed {
        logic frame_start; // falling edge seen while hunting
        logic mid_data;    // mid-point sample of a data bit
        logic end_data;    // last tick of a data bit
        logic last_end;    // last tick of the final data bit
        logic mid_stop;    // mid-point sample of the stop bit
        logic bit_val;     // line level at the current tick
    } rx_evt_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v == lim - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/fskd_timing.sv
module fskd_timing
    import fskd_pkg::*;
#(
    parameter int OS    = 16,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             line,
    output rx_evt_t          evt,
    output logic [DBITS-1:0] byte_q,
    output logic             in_data,
    output logic             in_stop
);
    localparam int PW   = $clog2(OS);
    localparam int BW   = $clog2(DBITS);
    localparam int HALF = OS / 2;
    localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(OS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DBITS - 1);

    rx_state_e        state;
    logic [PW-1:0]    ph;
    logic [BW-1:0]    bcnt;
    logic [DBITS-1:0] sh;
    logic             mid, wrap;

    always_comb begin
        mid  = os_tick && (ph == PH_MID);
        wrap = os_tick && (ph == PH_LAST);
        evt.frame_start = (state == ST_HUNT) && os_tick && !line;
        evt.mid_data    = (state == ST_DATA) && mid;
        evt.end_data    = (state == ST_DATA) && wrap;
        evt.last_end    = (state == ST_DATA) && wrap && (bcnt == BIT_LAST);
        evt.mid_stop    = (state == ST_STOP) && mid;
        evt.bit_val     = line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            ph    <= '0;
            bcnt  <= '0;
            sh    <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (evt.frame_start) begin
                        state <= ST_START;
                        ph    <= '0;
                    end
                end
                ST_START: begin
                    if (os_tick) begin
                        if (mid && line) begin
                            state <= ST_HUNT;
                        end else begin
                            ph <= PW'(wrap_inc(32'(ph), OS));
                            if (wrap) begin
                                state <= ST_DATA;
                                bcnt  <= '0;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (os_tick) begin
                        ph <= PW'(wrap_inc(32'(ph), OS));
                        if (mid) sh <= {line, sh[DBITS-1:1]};
                        if (wrap) begin
                            if (bcnt == BIT_LAST) state <= ST_STOP;
                            else                  bcnt  <= bcnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (os_tick) begin
                        ph <= PW'(wrap_inc(32'(ph), OS));
                        if (mid) state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    assign byte_q  = sh;
    assign in_data = (state == ST_DATA);
    assign in_stop = (state == ST_STOP);

    // R6: a high line at the start-bit centre abandons the frame
    a_r6_false_start_hunt: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && os_tick && ph == PH_MID && line) |=> (state == ST_HUNT));

    // R5: the stop bit is always entered from the last data bit
    a_r5_stop_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_STOP) |-> ($past(state) == ST_DATA && $past(bcnt) == BIT_LAST));

endmodule

// File: rtl/fskd_strobe.sv
module fskd_strobe
    import fskd_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    os_tick,
    input  rx_evt_t evt,
    output logic    dclk_q,
    output logic    dr_n_q,
    output logic    ferr_q
);
    localparam int PW   = $clog2(OS);
    localparam int HALF = OS / 2;

    logic [PW:0] clk_hi_ticks;
    logic [PW:0] dr_lo_ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q <= 1'b0;
            dr_n_q <= 1'b1;
            ferr_q <= 1'b0;
        end else begin
            if (evt.mid_data)      dclk_q <= 1'b1;
            else if (evt.end_data) dclk_q <= 1'b0;
            if (evt.last_end)      dr_n_q <= 1'b0;
            else if (evt.mid_stop) dr_n_q <= 1'b1;
            ferr_q <= evt.mid_stop && !evt.bit_val;
        end
    end

    // Pulse-width observers for the assertions below
    always_ff @(posedge clk) begin
        if (rst || evt.frame_start) begin
            clk_hi_ticks <= '0;
            dr_lo_ticks  <= '0;
        end else begin
            if (evt.mid_data)            clk_hi_ticks <= '0;
            else if (dclk_q && os_tick)  clk_hi_ticks <= clk_hi_ticks + 1'b1;
            if (evt.last_end)            dr_lo_ticks  <= '0;
            else if (!dr_n_q && os_tick) dr_lo_ticks  <= dr_lo_ticks + 1'b1;
        end
    end

    // R3: each data-clock pulse lasts half a bit
    a_r3_dclk_half_bit: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk_q) |-> (clk_hi_ticks == (PW+1)'(HALF)));

    // R5: data ready stays low for half a bit
    a_r5_dr_half_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_n_q) |-> (dr_lo_ticks == (PW+1)'(HALF)));

    // R10: framing error is a single-cycle pulse
    a_r10_ferr_single: assert property (@(posedge clk) disable iff (rst)
        ferr_q |=> !ferr_q);

endmodule

// File: rtl/fskd_buf.sv
module fskd_buf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         q0,
    output logic         ready_n
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '1;
            ready_n <= 1'b1;
        end else if (load) begin
            sr      <= din;
            ready_n <= 1'b0;
        end else if (shift) begin
            sr      <= {1'b1, sr[W-1:1]};
            ready_n <= 1'b1;
        end
    end

    assign q0 = sr[0];

    // R9: a load raises data ready (active low)
    a_r9_load_ready: assert property (@(posedge clk) disable iff (rst)
        load |=> !ready_n);

    // R9: a host read releases data ready
    a_r9_read_release: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> ready_n);

    // R8: each read advances the register by one place
    a_r8_shift_advance: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (q0 == $past(sr[1])));

endmodule

// File: rtl/fsk_deframer.sv
module fsk_deframer
    import fskd_pkg::*;
#(
    parameter int OS    = 16,
    parameter int DBITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    input  logic serial_in,
    input  logic mode,
    input  logic host_shift,
    output logic data_out,
    output logic dclk_out,
    output logic dr_n,
    output logic frame_err
);
    localparam int BW = $clog2(DBITS) + 1;

    rx_evt_t          evt;
    logic [DBITS-1:0] byte_q;
    logic             in_data, in_stop;
    logic             dclk_q, str_dr_n, buf_q0, buf_dr_n;

    fskd_timing #(.OS(OS), .DBITS(DBITS)) u_timing (
        .clk(clk), .rst(rst), .os_tick(os_tick), .line(serial_in),
        .evt(evt), .byte_q(byte_q), .in_data(in_data), .in_stop(in_stop)
    );

    fskd_strobe #(.OS(OS)) u_strobe (
        .clk(clk), .rst(rst), .os_tick(os_tick), .evt(evt),
        .dclk_q(dclk_q), .dr_n_q(str_dr_n), .ferr_q(frame_err)
    );

    fskd_buf #(.W(DBITS + 1)) u_buf (
        .clk(clk), .rst(rst), .load(evt.mid_stop),
        .din({evt.bit_val, byte_q}), .shift(host_shift),
        .q0(buf_q0), .ready_n(buf_dr_n)
    );

    assign data_out = mode ? buf_q0   : serial_in;
    assign dclk_out = mode ? 1'b0     : dclk_q;
    assign dr_n     = mode ? buf_dr_n : str_dr_n;

    // Rising-edge counter used to check the pulse count per frame
    logic          dclk_d;
    logic [BW-1:0] n_rises;
    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_d  <= 1'b0;
            n_rises <= '0;
        end else begin
            dclk_d <= dclk_q;
            if (evt.frame_start)      n_rises <= '0;
            else if (dclk_q && !dclk_d) n_rises <= n_rises + 1'b1;
        end
    end

    // R3: eight data-clock rises precede every stop sample
    a_r3_eight_pulses: assert property (@(posedge clk) disable iff (rst)
        evt.mid_stop |-> (n_rises == BW'(DBITS)));

    // R4: the data clock is high only inside data bits
    a_r4_dclk_in_data: assert property (@(posedge clk) disable iff (rst)
        dclk_q |-> in_data);

    // R5: the stream-mode ready pulse lies inside the stop bit
    a_r5_dr_in_stop: assert property (@(posedge clk) disable iff (rst)
        !str_dr_n |-> in_stop);

endmodule

// File: tb/fsk_deframer_test.sv
module fsk_deframer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic serial_in = 1'b1;
    logic mode = 1'b0;
    logic host_shift = 1'b0;
    logic data_out, dclk_out, dr_n, frame_err;

    always #4 clk = ~clk; // 125 MHz

    fsk_deframer uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .serial_in(serial_in),
        .mode(mode), .host_shift(host_shift), .data_out(data_out),
        .dclk_out(dclk_out), .dr_n(dr_n), .frame_err(frame_err)
    );

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    int divc   = 0;
    bit done   = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        divc <= (divc == 3) ? 0 : divc + 1;
        os_tick <= (divc == 3);
    end

    // Monitor state
    int c0;
    int rise_n, fall_n, dr_fall_n, fe_n;
    int rise_t[8];
    int fall_t[8];
    logic [7:0] got_byte;
    int dr_fall_t, dr_rise_t, fe_t, pass_bad;
    logic p_dclk = 1'b0, p_dr = 1'b1;

    initial pass_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dclk_out && !p_dclk) begin
                if (rise_n < 8) begin
                    rise_t[rise_n] = cyc;
                    got_byte[rise_n] = data_out;
                end
                rise_n++;
            end
            if (!dclk_out && p_dclk) begin
                if (fall_n < 8) fall_t[fall_n] = cyc;
                fall_n++;
            end
            if (!dr_n && p_dr) begin dr_fall_n++; dr_fall_t = cyc; end
            if (dr_n && !p_dr) dr_rise_t = cyc;
            if (frame_err) begin fe_n++; fe_t = cyc; end
            if (!mode && data_out !== serial_in) pass_bad++;
        end
        p_dclk = dclk_out;
        p_dr   = dr_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int t_at(int n);
        return c0 + 1 + 4 * n;
    endfunction
    function automatic int exp_rise(int i); return t_at(24 + 16 * i); endfunction
    function automatic int exp_fall(int i); return t_at(32 + 16 * i); endfunction

    task automatic next_slot();
        @(negedge clk);
        while (!os_tick) @(negedge clk);
    endtask

    task automatic clear_mon();
        rise_n = 0; fall_n = 0; dr_fall_n = 0; fe_n = 0;
        got_byte = '0; dr_fall_t = -1; dr_rise_t = -1; fe_t = -1;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopv, input int idle);
        next_slot();
        clear_mon();
        c0 = cyc;
        serial_in = 1'b0;
        repeat (16) next_slot();
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i];
            repeat (16) next_slot();
        end
        serial_in = stopv;
        repeat (16) next_slot();
        serial_in = 1'b1;
        repeat (idle) next_slot();
    endtask

    task automatic check_stream(input logic [7:0] b, input logic stopv);
        chk(rise_n == 8, "R3 dclk rise count", rise_n, 8);
        chk(fall_n == 8, "R4 dclk fall count", fall_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk(rise_t[i] == exp_rise(i), "R3 dclk rise cycle", rise_t[i], exp_rise(i));
            chk(fall_t[i] == exp_fall(i), "R3 dclk fall cycle", fall_t[i], exp_fall(i));
        end
        chk(got_byte == b, "R7 assembled byte", got_byte, b);
        chk(dr_fall_n == 1, "R5 dr pulse count", dr_fall_n, 1);
        chk(dr_fall_t == t_at(144), "R5 dr fall cycle", dr_fall_t, t_at(144));
        chk(dr_rise_t == t_at(152), "R5 dr rise cycle", dr_rise_t, t_at(152));
        chk(fe_n == (stopv ? 0 : 1), "R10 frame_err count", fe_n, stopv ? 0 : 1);
        if (!stopv) chk(fe_t == t_at(152), "R10 frame_err cycle", fe_t, t_at(152));
    endtask

    task automatic read_buffer(input logic [7:0] b, input logic stopv);
        logic [8:0] exp9;
        exp9 = {stopv, b};
        chk(dr_n == 1'b0, "R9 dr_n low after load", dr_n, 0);
        chk(fe_n == (stopv ? 0 : 1), "R10 frame_err count buffer mode", fe_n, stopv ? 0 : 1);
        chk(rise_n == 0, "R4 no dclk in buffer mode", rise_n, 0);
        for (int k = 0; k < 9; k++) begin
            chk(data_out == exp9[k], "R8 buffer read bit", data_out, exp9[k]);
            host_shift = 1'b1;
            @(negedge clk);
            host_shift = 1'b0;
            if (k == 0) chk(dr_n == 1'b1, "R9 dr_n high after read", dr_n, 1);
        end
        chk(data_out == 1'b1, "R8 fill with ones", data_out, 1);
    endtask

    task automatic false_start(input int low_ticks);
        next_slot();
        clear_mon();
        serial_in = 1'b0;
        repeat (low_ticks) next_slot();
        serial_in = 1'b1;
        repeat (24) next_slot();
        chk(rise_n == 0, "R6 no dclk after false start", rise_n, 0);
        chk(dr_fall_n == 0, "R6 no dr after false start", dr_fall_n, 0);
        chk(fe_n == 0, "R6 no frame_err after false start", fe_n, 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        int unsigned seedv;
        logic [7:0] rb;
        logic rs;
        seedv = $urandom(32'd2718);
        clear_mon();
        repeat (3) @(negedge clk);
        chk(dclk_out == 1'b0, "R1 dclk in reset", dclk_out, 0);
        chk(dr_n == 1'b1, "R1 dr_n in reset", dr_n, 1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dclk_out == 1'b0, "R1 dclk after reset", dclk_out, 0);
        chk(dr_n == 1'b1, "R1 dr_n after reset", dr_n, 1);
        chk(frame_err == 1'b0, "R1 frame_err after reset", frame_err, 0);
        mode = 1'b1;
        #1;
        chk(data_out == 1'b1, "R1 buffer data_out after reset", data_out, 1);
        chk(dr_n == 1'b1, "R1 buffer dr_n after reset", dr_n, 1);
        mode = 1'b0;
        repeat (8) next_slot();

        // Directed stream-mode frames
        send_frame(8'h55, 1'b1, 6); check_stream(8'h55, 1'b1);
        send_frame(8'h00, 1'b0, 6); check_stream(8'h00, 1'b0);
        send_frame(8'h80, 1'b1, 4); check_stream(8'h80, 1'b1);
        false_start(4);
        false_start(8);
        send_frame(8'hA5, 1'b1, 5); check_stream(8'hA5, 1'b1);

        // Random stream-mode frames
        for (int n = 0; n < 16; n++) begin
            rb = 8'($urandom);
            rs = ($urandom % 5) != 0;
            send_frame(rb, rs, 4 + int'($urandom % 12));
            check_stream(rb, rs);
        end
        chk(pass_bad == 0, "R2 stream passthrough mismatches", pass_bad, 0);

        // Buffer mode
        mode = 1'b1;
        send_frame(8'h3C, 1'b1, 4); read_buffer(8'h3C, 1'b1);
        send_frame(8'hFF, 1'b0, 4); read_buffer(8'hFF, 1'b0);
        for (int n = 0; n < 6; n++) begin
            rb = 8'($urandom);
            rs = ($urandom % 4) != 0;
            send_frame(rb, rs, 4 + int'($urandom % 8));
            read_buffer(rb, rs);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule